// File: doc/BRIEF.md
# Strobed Port Handshake Channel

This block is one handshake channel that sits beside an 8-bit parallel port running in strobed mode. A static configuration input picks the direction. As an input channel, the peripheral pulls a strobe low to latch the pin data into a holding register. The block then reports the buffer as full. When the strobe is released, it raises an interrupt request if interrupts are enabled. A processor read of the holding register withdraws the request, and the end of that read empties the buffer.

As an output channel, a processor write loads the output register and withdraws any pending request. When the write ends, an active-low buffer-full line tells the peripheral that data is waiting. The peripheral's acknowledge pulse releases that line. The rising edge of the acknowledge raises an interrupt request if interrupts are enabled.

Each channel has one interrupt-enable flip-flop. It changes only through a single-bit set/clear command aimed at a port C line number. The channel also places its handshake bits and its enable bit into a status byte. The surrounding port logic returns that byte in place of port C pin data. A parameter selects whether the instance is the upper channel or the lower channel. That choice sets the command bit number and the status bit positions. All pins are sampled on the clock, and every edge is detected against the value registered at the previous edge.

Top module: `strobe_port_chan`

## Requirements
- R1: In input direction, a falling `stb_n` (high at the previous edge, low at this edge) copies `pin_in` into `cpu_rdata` and sets `ibf` at that same edge.
- R2: In input direction, a rising `cpu_rd` clears the stored interrupt request, and a falling `cpu_rd` clears `ibf`.
- R3: In input direction, a rising `stb_n` sets the stored interrupt request only if the enable flip-flop was already 1 before that edge. Otherwise the request stays clear.
- R4: In output direction, `pin_out` takes `cpu_wdata` at every edge where `cpu_wr` is high. A rising `cpu_wr` clears the stored request. A falling `cpu_wr` drives `obf_n` low.
- R5: In output direction, a falling `ack_n` drives `obf_n` high. A rising `ack_n` sets the stored request only if the enable flip-flop was already 1.
- R6: The enable flip-flop takes `bsr_val` only when `bsr_valid` is high and `bsr_sel` matches the channel's line number: 4 for the upper channel in input direction, 6 for the upper channel in output direction, and 2 for the lower channel in either direction. Any other number leaves it unchanged.
- R7: `intr` is the stored request masked by the enable flip-flop. Clearing the enable hides a pending request without discarding it, and setting the enable again shows the request once more.
- R8: `stat_word` and `stat_mask` follow this layout. Upper channel, input: bit5=`ibf`, bit4=enable, bit3=`intr`, mask 0x38. Upper channel, output: bit7=`obf_n`, bit6=enable, bit3=`intr`, mask 0xC8. Lower channel: bit2=enable, bit1=`ibf` (input) or `obf_n` (output), bit0=`intr`, mask 0x07. All other bits are 0.
- R9: When `cfg_dir_in` differs from the direction in effect, the next edge adopts the new direction, clears `ibf` and the stored request, and drives `obf_n` high. The enable flip-flop is kept.
- R10: After reset: input direction, `ibf`=0, `obf_n`=1, `intr`=0, enable=0, `cpu_rdata`=0, `pin_out`=0.
- R11: When a setting event and a clearing event fall on the same edge, the setting event wins. This applies to strobe fall over read end, write end over acknowledge fall, and a request raise over a request clear.
- R12: Edges that belong to the inactive direction (`stb_n` and `cpu_rd` in output direction, `ack_n` and `cpu_wr` in input direction) have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dir_in | input | 1 | 1 = input direction, 0 = output direction |
| cpu_rd | input | 1 | Processor read of the holding register, active high |
| cpu_wr | input | 1 | Processor write of the output register, active high |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Latched input data |
| bsr_valid | input | 1 | Single-bit set/clear command strobe |
| bsr_sel | input | 3 | Port C line number addressed by the command |
| bsr_val | input | 1 | Value written by the command |
| stb_n | input | 1 | Peripheral strobe, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| pin_in | input | DW | Port pins, input direction |
| pin_out | output | DW | Port pins, output direction |
| ibf | output | 1 | Input buffer full |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request |
| stat_word | output | 8 | Status bits in port C positions |
| stat_mask | output | 8 | Port C positions owned by this channel |

## Verification
Two instances, one per channel, receive the same pins. A single command therefore hits the enable of one channel and misses the other, which separates the line-number decode for each channel and each direction. Directed sequences cover these cases:
- Strobes with the enable clear and with it set, which tells gating at the raise apart from masking at the output.
- Read and write pulses that overlap strobe or acknowledge edges, which exposes the same-edge priority.
- Direction flips with work pending, plus pulses on the idle direction's pins.

A long stretch of random pin activity then runs against a per-cycle behavioural model.

// File: rtl/strobe_port_pkg.sv
package strobe_port_pkg;

    typedef struct packed {
        logic dir_in;
        logic ibf;
        logic obf_n;
        logic req;
        logic inte;
    } chan_flags_t;

    localparam logic [2:0] SEL_UPPER_IN  = 3'd4;
    localparam logic [2:0] SEL_UPPER_OUT = 3'd6;
    localparam logic [2:0] SEL_LOWER     = 3'd2;

    function automatic logic [2:0] inte_line(input bit upper, input logic dir_in);
        if (!upper) return SEL_LOWER;
        return dir_in ? SEL_UPPER_IN : SEL_UPPER_OUT;
    endfunction

endpackage

// File: rtl/strobe_edge_det.sv
module strobe_edge_det #(
    parameter int          N       = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
        rise   = sig & ~prev_q;
        fall   = ~sig & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/strobe_status_fmt.sv
module strobe_status_fmt #(
    parameter bit UPPER = 1'b1
) (
    input  logic       dir_in,
    input  logic       ibf,
    input  logic       obf_n,
    input  logic       intr,
    input  logic       inte,
    output logic [7:0] word,
    output logic [7:0] mask
);
    generate
        if (UPPER) begin : g_upper
            always_comb begin
                word = '0;
                word[3] = intr;
                if (dir_in) begin
                    word[5] = ibf;
                    word[4] = inte;
                    mask    = 8'h38;
                end else begin
                    word[7] = obf_n;
                    word[6] = inte;
                    mask    = 8'hC8;
                end
            end
        end else begin : g_lower
            always_comb begin
                word    = '0;
                word[2] = inte;
                word[1] = dir_in ? ibf : obf_n;
                word[0] = intr;
                mask    = 8'h07;
            end
        end
    endgenerate
endmodule

// File: rtl/strobe_port_chan.sv
module strobe_port_chan
    import strobe_port_pkg::*;
#(
    parameter int DW    = 8,
    parameter bit UPPER = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_dir_in,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic          bsr_valid,
    input  logic [2:0]    bsr_sel,
    input  logic          bsr_val,
    input  logic          stb_n,
    input  logic          ack_n,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] pin_out,
    output logic          ibf,
    output logic          obf_n,
    output logic          intr,
    output logic [7:0]    stat_word,
    output logic [7:0]    stat_mask
);
    localparam int NSIG = 4;
    localparam int I_STB = 0, I_ACK = 1, I_RD = 2, I_WR = 3;

    logic [NSIG-1:0] rise, fall;
    chan_flags_t     flags_d, flags_q;
    logic [DW-1:0]   in_d, in_q, out_d, out_q;
    logic            stb_fall, stb_rise, ack_fall, ack_rise;
    logic            rd_rise, rd_fall, wr_rise, wr_fall;

    strobe_edge_det #(.N(NSIG), .RST_VAL(4'b0011)) i_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  ({cpu_wr, cpu_rd, ack_n, stb_n}),
        .rise (rise),
        .fall (fall)
    );

    assign stb_fall = fall[I_STB];
    assign stb_rise = rise[I_STB];
    assign ack_fall = fall[I_ACK];
    assign ack_rise = rise[I_ACK];
    assign rd_fall  = fall[I_RD];
    assign rd_rise  = rise[I_RD];
    assign wr_fall  = fall[I_WR];
    assign wr_rise  = rise[I_WR];

    always_comb begin
        flags_d        = flags_q;
        in_d           = in_q;
        out_d          = out_q;
        flags_d.dir_in = cfg_dir_in;
        if (flags_q.dir_in) begin
            // clearing events first so that setting events win (R11)
            if (rd_rise)  flags_d.req = 1'b0;
            if (rd_fall)  flags_d.ibf = 1'b0;
            if (stb_fall) begin
                in_d        = pin_in;
                flags_d.ibf = 1'b1;
            end
            if (stb_rise && flags_q.inte) flags_d.req = 1'b1;
        end else begin
            if (cpu_wr)   out_d = cpu_wdata;
            if (wr_rise)  flags_d.req = 1'b0;
            if (ack_fall) flags_d.obf_n = 1'b1;
            if (wr_fall)  flags_d.obf_n = 1'b0;
            if (ack_rise && flags_q.inte) flags_d.req = 1'b1;
        end
        if (bsr_valid && bsr_sel == inte_line(UPPER, flags_q.dir_in))
            flags_d.inte = bsr_val;
        if (cfg_dir_in != flags_q.dir_in) begin
            flags_d.ibf   = 1'b0;
            flags_d.obf_n = 1'b1;
            flags_d.req   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '{dir_in: 1'b1, ibf: 1'b0, obf_n: 1'b1, req: 1'b0, inte: 1'b0};
            in_q    <= '0;
            out_q   <= '0;
        end else begin
            flags_q <= flags_d;
            in_q    <= in_d;
            out_q   <= out_d;
        end
    end

    assign cpu_rdata = in_q;
    assign pin_out   = out_q;
    assign ibf       = flags_q.ibf;
    assign obf_n     = flags_q.obf_n;
    assign intr      = flags_q.req & flags_q.inte;

    strobe_status_fmt #(.UPPER(UPPER)) i_stat (
        .dir_in(flags_q.dir_in),
        .ibf   (flags_q.ibf),
        .obf_n (flags_q.obf_n),
        .intr  (intr),
        .inte  (flags_q.inte),
        .word  (stat_word),
        .mask  (stat_mask)
    );

    p_ibf_from_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q.ibf) |-> $past(stb_fall));
    p_obf_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_q.obf_n) |-> $past(wr_fall) && !$past(flags_q.dir_in));
    p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags_q.dir_in && ack_fall && !wr_fall) |=> flags_q.obf_n);
    p_inte_by_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flags_q.inte) |-> $past(bsr_valid));
    p_obf_idle_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q.dir_in |-> flags_q.obf_n);
    p_ibf_idle_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_q.dir_in |-> !flags_q.ibf);
endmodule

// File: tb/test_strobe_port_chan.sv
`timescale 1ns/1ps
module test_strobe_port_chan;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_dir_in = 1'b1, cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [DW-1:0] cpu_wdata = '0, pin_in = '0;
    logic bsr_valid = 1'b0, bsr_val = 1'b0;
    logic [2:0] bsr_sel = '0;
    logic stb_n = 1'b1, ack_n = 1'b1;

    logic [DW-1:0] rdata [2], pout [2];
    logic ibf_o [2], obf_o [2], intr_o [2];
    logic [7:0] sw [2], sm [2];

    always #2.5 clk = ~clk;

    strobe_port_chan #(.DW(DW), .UPPER(1'b1)) i_strobe_port_chan (
        .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(rdata[0]), .bsr_valid(bsr_valid), .bsr_sel(bsr_sel),
        .bsr_val(bsr_val), .stb_n(stb_n), .ack_n(ack_n), .pin_in(pin_in), .pin_out(pout[0]),
        .ibf(ibf_o[0]), .obf_n(obf_o[0]), .intr(intr_o[0]), .stat_word(sw[0]), .stat_mask(sm[0]));

    strobe_port_chan #(.DW(DW), .UPPER(1'b0)) i_strobe_port_chan_lo (
        .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(rdata[1]), .bsr_valid(bsr_valid), .bsr_sel(bsr_sel),
        .bsr_val(bsr_val), .stb_n(stb_n), .ack_n(ack_n), .pin_in(pin_in), .pin_out(pout[1]),
        .ibf(ibf_o[1]), .obf_n(obf_o[1]), .intr(intr_o[1]), .stat_word(sw[1]), .stat_mask(sm[1]));

    int checks = 0, failures = 0;
    string tag = "R10";
    bit done = 1'b0;

    // reference model, index 0 = upper channel, 1 = lower channel
    bit m_dir [2], m_ibf [2], m_obf [2], m_req [2], m_inte [2];
    int m_in [2], m_out [2];
    bit p_stb = 1, p_ack = 1, p_rd = 0, p_wr = 0;

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int sel_for(input int c, input bit dir);
        if (c == 1) return 2;
        return dir ? 4 : 6;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_dir[c] = 1; m_ibf[c] = 0; m_obf[c] = 1; m_req[c] = 0; m_inte[c] = 0;
            m_in[c] = 0; m_out[c] = 0;
        end
        p_stb = 1; p_ack = 1; p_rd = 0; p_wr = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model_reset();
        else begin
            for (int c = 0; c < 2; c++) begin
                bit ni, no, nr, ne;
                ni = m_ibf[c]; no = m_obf[c]; nr = m_req[c]; ne = m_inte[c];
                if (m_dir[c]) begin
                    if (!p_rd && cpu_rd) nr = 0;
                    if (p_rd && !cpu_rd) ni = 0;
                    if (p_stb && !stb_n) begin m_in[c] = pin_in; ni = 1; end
                    if (!p_stb && stb_n && m_inte[c]) nr = 1;
                end else begin
                    if (cpu_wr) m_out[c] = cpu_wdata;
                    if (!p_wr && cpu_wr) nr = 0;
                    if (p_ack && !ack_n) no = 1;
                    if (p_wr && !cpu_wr) no = 0;
                    if (!p_ack && ack_n && m_inte[c]) nr = 1;
                end
                if (bsr_valid && int'(bsr_sel) == sel_for(c, m_dir[c])) ne = bsr_val;
                if (cfg_dir_in != m_dir[c]) begin ni = 0; no = 1; nr = 0; end
                m_dir[c] = cfg_dir_in; m_ibf[c] = ni; m_obf[c] = no; m_req[c] = nr; m_inte[c] = ne;
            end
            p_stb = stb_n; p_ack = ack_n; p_rd = cpu_rd; p_wr = cpu_wr;
        end
    end

    function automatic int exp_word(input int c);
        int w = 0;
        bit it = m_req[c] & m_inte[c];
        if (c == 0) begin
            w[3] = it;
            if (m_dir[c]) begin w[5] = m_ibf[c]; w[4] = m_inte[c]; end
            else begin w[7] = m_obf[c]; w[6] = m_inte[c]; end
        end else begin
            w[2] = m_inte[c]; w[1] = m_dir[c] ? m_ibf[c] : m_obf[c]; w[0] = it;
        end
        return w;
    endfunction

    function automatic int exp_mask(input int c);
        if (c == 1) return 8'h07;
        return m_dir[c] ? 8'h38 : 8'hC8;
    endfunction

    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            for (int c = 0; c < 2; c++) begin
                check($sformatf("ch%0d rdata", c), rdata[c], m_in[c]);
                check($sformatf("ch%0d pin_out", c), pout[c], m_out[c]);
                check($sformatf("ch%0d ibf", c), ibf_o[c], m_ibf[c]);
                check($sformatf("ch%0d obf_n", c), obf_o[c], m_obf[c]);
                check($sformatf("ch%0d intr", c), intr_o[c], m_req[c] & m_inte[c]);
                check($sformatf("ch%0d stat_word", c), sw[c], exp_word(c));
                check($sformatf("ch%0d stat_mask", c), sm[c], exp_mask(c));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bsr(input int sel, input bit v);
        bsr_valid = 1; bsr_sel = 3'(sel); bsr_val = v; tick(1); bsr_valid = 0; tick(1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        tick(3);
        tag = "R10";
        for (int c = 0; c < 2; c++) begin
            check("reset ibf", ibf_o[c], 0); check("reset obf_n", obf_o[c], 1);
            check("reset intr", intr_o[c], 0); check("reset rdata", rdata[c], 0);
            check("reset pin_out", pout[c], 0);
        end
        rst_n = 1; tick(2);

        tag = "R3";                        // strobe with enable clear: no request
        pin_in = 8'h11; stb_n = 0; tick(2); stb_n = 1; tick(2);
        check("R3 intr disabled ch0", intr_o[0], 0);
        tag = "R2"; cpu_rd = 1; tick(2); cpu_rd = 0; tick(2);

        tag = "R6";
        bsr(7, 1); bsr(6, 1);              // wrong for input direction
        check("R6 inte untouched ch0", sw[0][4], 0);
        bsr(4, 1); bsr(2, 1);
        check("R6 inte upper", sw[0][4], 1);
        check("R6 inte lower", sw[1][2], 1);

        tag = "R1"; pin_in = 8'hA5; stb_n = 0; tick(1);
        check("R1 rdata", rdata[0], 8'hA5); check("R1 ibf", ibf_o[0], 1);
        pin_in = 8'h00; tick(1); tag = "R3"; stb_n = 1; tick(1);
        check("R3 intr ch0", intr_o[0], 1); check("R3 intr ch1", intr_o[1], 1);

        tag = "R7"; bsr(4, 0);
        check("R7 masked", intr_o[0], 0);
        bsr(4, 1);
        check("R7 unmasked", intr_o[0], 1);

        tag = "R2"; cpu_rd = 1; tick(1);
        check("R2 intr cleared", intr_o[0], 0); check("R2 ibf held", ibf_o[0], 1);
        tick(1); cpu_rd = 0; tick(1);
        check("R2 ibf cleared", ibf_o[0], 0);

        tag = "R11"; pin_in = 8'h5A; cpu_rd = 1; tick(2);
        cpu_rd = 0; stb_n = 0; tick(1);
        check("R11 ibf set wins", ibf_o[0], 1);
        stb_n = 1; tick(2);

        tag = "R12"; ack_n = 0; cpu_wr = 1; cpu_wdata = 8'hEE; tick(2); ack_n = 1; cpu_wr = 0; tick(2);
        check("R12 pin_out untouched", pout[0], 0);

        tag = "R9"; cfg_dir_in = 0; tick(1);
        check("R9 ibf cleared", ibf_o[0], 0); check("R9 intr cleared", intr_o[1], 0);
        check("R9 inte kept lower", sw[1][2], 1);
        tag = "R6"; bsr(6, 1);
        check("R6 upper output enable", sw[0][6], 1);

        tag = "R4"; cpu_wdata = 8'h3C; cpu_wr = 1; tick(2); cpu_wr = 0; tick(1);
        check("R4 obf_n low", obf_o[0], 0); check("R4 pin_out", pout[0], 8'h3C);
        tag = "R5"; ack_n = 0; tick(1);
        check("R5 obf_n released", obf_o[0], 1);
        ack_n = 1; tick(1);
        check("R5 intr", intr_o[0], 1);

        tag = "R11"; cpu_wdata = 8'h77; cpu_wr = 1; tick(1); ack_n = 0; cpu_wr = 0; tick(1);
        check("R11 obf_n assert wins", obf_o[0], 0);
        ack_n = 1; tick(2);

        tag = "R12"; pin_in = 8'hC3; stb_n = 0; cpu_rd = 1; tick(2); stb_n = 1; cpu_rd = 0; tick(2);
        check("R12 rdata untouched", rdata[0], 8'h5A);

        tag = "R8"; cfg_dir_in = 1; tick(2);
        check("R8 mask upper input", sm[0], 8'h38);

        tag = "R12";
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            if (r < 10) stb_n = ~stb_n;
            else if (r < 20) ack_n = ~ack_n;
            else if (r < 28) cpu_rd = ~cpu_rd;
            else if (r < 36) cpu_wr = ~cpu_wr;
            else if (r < 38) cfg_dir_in = ~cfg_dir_in;
            pin_in = 8'($urandom); cpu_wdata = 8'($urandom);
            bsr_valid = ($urandom_range(0, 19) == 0);
            bsr_sel = 3'($urandom); bsr_val = 1'($urandom);
            tick(1);
        end
        bsr_valid = 0; tick(2);
        finish_run();
    end
endmodule